// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block runs the per-byte flow control of a slow side channel that is carried once per TDM frame. Each frame carries one data byte and two handshake bits. The transmitter owns the send-strobe bit, and the receiver owns the acknowledge bit. Both bits are active low. The block holds both halves: a transmit engine that places host bytes in the frame and waits for the far end to acknowledge each one, and a receive engine that captures incoming bytes and acknowledges them. A frame serializer outside the block supplies a one-cycle `frame_tick` at each frame boundary. At that tick it presents the handshake bits and data byte received in the frame just ended. It takes the block's registered outputs for the frame that follows.

On the transmit side, the host writes a byte and holds the message-control input high. The engine raises the strobe with the byte, waits for an acknowledge edge, and reports it with a one-cycle interrupt. After that, the host supplies the next byte. When the host drops message control, the strobe stays released. The busy flag clears only after the line has been quiet for two frames. If the far receiver refuses a byte, the transmitter flags an abort. If an optional 32-frame watchdog expires while it waits for an acknowledge, it flags a time-out. On the receive side, each byte is taken on a strobe edge and acknowledged in the next frame. Interrupts report the arrival of a byte, the end of a message, and a byte that had to be refused because the host had not collected the previous one.

Top module: `mon_hs`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mx_n` and `mr_n` are 1, `tx_busy` is 0, and every interrupt output is 0.
- R2: With `tx_ctrl`=1 and a byte written through `tx_wr`, the next frame tick with the engine idle drives `mx_n` to 0, places the byte on `mon_out` and sets `tx_busy`.
- R3: While the strobe is active, an acknowledge is a frame in which `mr_in_n` is 0 after a frame in which it was 1. On that tick, `tx_ack_irq` pulses for one cycle and `mx_n` returns to 1. At the next tick, a pending byte is sent with `mx_n` at 0 again.
- R4: If `mr_in_n` is 1 in two consecutive sampled frames while the strobe is active, `tx_abort_irq` pulses and `mx_n` returns to 1.
- R5: With `tmo_en`=1, a wait that sees neither an acknowledge nor an abort ends at the 32nd sampled frame: `tx_tmo_irq` pulses and `mx_n` returns to 1. With `tmo_en`=0, the wait has no limit.
- R6: After `tx_ctrl` is cleared between bytes, or after an abort or time-out, `tx_busy` falls at the second consecutive sampled frame with `mr_in_n`=1.
- R7: When `rx_en`=1, a frame with `mx_in_n` 0 after a frame with it at 1 is a new byte. `mon_in` is captured into `rx_data`, and `mr_n` goes to 0 for the next frame and stays there until a frame with `mx_in_n`=1 is sampled. `rx_first` is 1 only for the first byte of a message.
- R8: `rx_byte_irq` needs both `rx_en`=1 and `rx_ie`=1. With `rx_en`=0, nothing is captured and `mr_n` stays at 1. With `rx_ie`=0, bytes are still captured and acknowledged.
- R9: A new byte that arrives before `rx_take` has collected the previous one pulses `rx_err_irq`. It is not acknowledged (`mr_n` stays 1), and `rx_data` keeps the earlier byte.
- R10: After at least one byte, two consecutive sampled frames with `mx_in_n`=1 and `mr_n`=1 end the received message, and `rx_eom_irq` pulses if `rx_ie`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| tx_data | input | DW | Byte to send |
| tx_wr | input | 1 | Load `tx_data` as the pending byte |
| tx_ctrl | input | 1 | Message control: high keeps the message open |
| tmo_en | input | 1 | Enable the 32-frame acknowledge watchdog |
| rx_en | input | 1 | Allow the receiver to capture and acknowledge |
| rx_ie | input | 1 | Enable byte and end-of-message interrupts |
| rx_take | input | 1 | Host has collected `rx_data` |
| mx_in_n | input | 1 | Received strobe bit, active low |
| mr_in_n | input | 1 | Received acknowledge bit, active low |
| mon_in | input | DW | Received data byte |
| mx_n | output | 1 | Transmitted strobe bit, active low |
| mr_n | output | 1 | Transmitted acknowledge bit, active low |
| mon_out | output | DW | Transmitted data byte |
| tx_busy | output | 1 | Transmit message in progress |
| tx_ack_irq | output | 1 | Byte acknowledged |
| tx_abort_irq | output | 1 | Far receiver refused the byte |
| tx_tmo_irq | output | 1 | Acknowledge wait timed out |
| rx_data | output | DW | Last captured byte |
| rx_first | output | 1 | Captured byte opened a message |
| rx_byte_irq | output | 1 | Byte received |
| rx_eom_irq | output | 1 | Received message ended |
| rx_err_irq | output | 1 | Byte refused: previous one not collected |

## Verification
The assertions take `frame_tick` to be a single-cycle pulse with quiet cycles between pulses. They also assume that the line inputs are settled at each tick, so that the value seen one cycle before an output change is the one the engine used. The bench generates a tick every fourth cycle and wires the strobe and data outputs back into the receive inputs. The acknowledge input is either looped back or forced through an override that the bench changes only on falling clock edges. That override is how stuck-active and refused acknowledges are produced without ever driving an input during the sampling edge.

// File: rtl/mon_hs.sv
module mon_hs #(
  parameter int DW         = 8,
  parameter int TMO_FRAMES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_wr,
  input  logic          tx_ctrl,
  input  logic          tmo_en,
  input  logic          rx_en,
  input  logic          rx_ie,
  input  logic          rx_take,
  input  logic          mx_in_n,
  input  logic          mr_in_n,
  input  logic [DW-1:0] mon_in,
  output logic          mx_n,
  output logic          mr_n,
  output logic [DW-1:0] mon_out,
  output logic          tx_busy,
  output logic          tx_ack_irq,
  output logic          tx_abort_irq,
  output logic          tx_tmo_irq,
  output logic [DW-1:0] rx_data,
  output logic          rx_first,
  output logic          rx_byte_irq,
  output logic          rx_eom_irq,
  output logic          rx_err_irq
);
  localparam int TW = $clog2(TMO_FRAMES + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP, S_END} st_t;

  st_t           st;
  logic          mx_act, mr_prev, miss, quiet, pend;
  logic [DW-1:0] pend_byte;
  logic [TW-1:0] tmr;

  wire mr_now  = ~mr_in_n;
  wire ack_seen = mr_now & ~mr_prev;
  wire last_tick = tmr == TW'(TMO_FRAMES - 1);

  assign mx_n    = ~mx_act;
  assign tx_busy = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      mx_act       <= 1'b0;
      mr_prev      <= 1'b0;
      miss         <= 1'b0;
      quiet        <= 1'b0;
      pend         <= 1'b0;
      pend_byte    <= '0;
      mon_out      <= '0;
      tmr          <= '0;
      tx_ack_irq   <= 1'b0;
      tx_abort_irq <= 1'b0;
      tx_tmo_irq   <= 1'b0;
    end else begin
      tx_ack_irq   <= 1'b0;
      tx_abort_irq <= 1'b0;
      tx_tmo_irq   <= 1'b0;
      if (frame_tick) begin
        mr_prev <= mr_now;
        case (st)
          S_IDLE, S_GAP: begin
            if (st == S_GAP && !tx_ctrl) begin
              st    <= S_END;
              quiet <= 1'b0;
            end else if (tx_ctrl && pend) begin
              mon_out <= pend_byte;
              pend    <= 1'b0;
              mx_act  <= 1'b1;
              st      <= S_SEND;
              tmr     <= '0;
              miss    <= 1'b0;
            end
          end
          S_SEND: begin
            if (ack_seen) begin
              tx_ack_irq <= 1'b1;
              mx_act     <= 1'b0;
              st         <= S_GAP;
            end else if (!mr_now && miss) begin
              tx_abort_irq <= 1'b1;
              mx_act       <= 1'b0;
              st           <= S_END;
              quiet        <= 1'b0;
            end else if (tmo_en && last_tick) begin
              tx_tmo_irq <= 1'b1;
              mx_act     <= 1'b0;
              st         <= S_END;
              quiet      <= 1'b0;
            end else begin
              miss <= ~mr_now;
              tmr  <= tmr + 1'b1;
            end
          end
          default: begin
            if (mr_now) quiet <= 1'b0;
            else begin
              quiet <= 1'b1;
              if (quiet) st <= S_IDLE;
            end
          end
        endcase
      end
      if (tx_wr) begin
        pend      <= 1'b1;
        pend_byte <= tx_data;
      end
    end
  end

  logic mx_prev, mr_act, full, in_msg, r_quiet;
  wire  mx_now = ~mx_in_n;

  assign mr_n = ~mr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx_prev     <= 1'b0;
      mr_act      <= 1'b0;
      full        <= 1'b0;
      in_msg      <= 1'b0;
      r_quiet     <= 1'b0;
      rx_data     <= '0;
      rx_first    <= 1'b0;
      rx_byte_irq <= 1'b0;
      rx_eom_irq  <= 1'b0;
      rx_err_irq  <= 1'b0;
    end else begin
      rx_byte_irq <= 1'b0;
      rx_eom_irq  <= 1'b0;
      rx_err_irq  <= 1'b0;
      if (rx_take) full <= 1'b0;
      if (frame_tick) begin
        mx_prev <= mx_now;
        if (!rx_en) mr_act <= 1'b0;
        else if (mx_now && !mx_prev) begin
          if (full && !rx_take) rx_err_irq <= 1'b1;
          else begin
            rx_data     <= mon_in;
            full        <= 1'b1;
            mr_act      <= 1'b1;
            rx_byte_irq <= rx_ie;
            rx_first    <= ~in_msg;
            in_msg      <= 1'b1;
          end
        end else if (!mx_now) mr_act <= 1'b0;
        if (!mx_now && !mr_act && in_msg) begin
          r_quiet <= ~r_quiet;
          if (r_quiet) begin
            in_msg     <= 1'b0;
            rx_eom_irq <= rx_ie;
          end
        end else r_quiet <= 1'b0;
      end
    end
  end
endmodule

module mon_hs_chk #(
  parameter int TMO_FRAMES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic frame_tick,
  input logic tmo_en,
  input logic rx_en,
  input logic rx_ie,
  input logic mx_in_n,
  input logic mr_in_n,
  input logic mx_n,
  input logic mr_n,
  input logic tx_busy,
  input logic tx_ack_irq,
  input logic tx_abort_irq,
  input logic tx_tmo_irq,
  input logic rx_byte_irq,
  input logic rx_eom_irq,
  input logic rx_err_irq
);
  logic [15:0] act_frames;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_frames <= '0;
    else if (mx_n) act_frames <= '0;
    else if (frame_tick && act_frames != 16'hFFFF) act_frames <= act_frames + 16'd1;
  end

  // R2
  start_drives_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $fell(mx_n));
  // R3
  ack_needs_mr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack_irq |-> (mx_n && !$past(mr_in_n) && $past(frame_tick)));
  // R4
  abort_on_silent_mr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort_irq |-> (mx_n && $past(mr_in_n)));
  // R5
  tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tmo_irq |-> (act_frames == 16'(TMO_FRAMES) && $past(tmo_en)));
  // R3
  tx_irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_ack_irq, tx_abort_irq, tx_tmo_irq}));
  // R6
  busy_ends_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> (mx_n && $past(mr_in_n)));
  // R7
  ack_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mr_n) |-> ($past(!mx_in_n) && $past(rx_en)));
  // R8
  byte_irq_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_irq |-> $past(rx_en && rx_ie));
  // R9
  refused_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_irq |-> mr_n);
  // R10
  eom_quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eom_irq |-> ($past(mx_in_n) && $past(mr_n) && $past(rx_ie)));
endmodule

bind mon_hs mon_hs_chk #(.TMO_FRAMES(TMO_FRAMES)) u_chk (.*);

// File: tb/tb_mon_hs.sv
`timescale 1ns/1ps
module tb_mon_hs;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, frame_tick = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_wr = 0, tx_ctrl = 0, tmo_en = 0, rx_en = 1, rx_ie = 1, rx_take = 0;
  logic ovr = 0, ovr_act = 0;
  logic mx_in_n, mr_in_n;
  logic [7:0] mon_in;
  logic mx_n, mr_n, tx_busy, tx_ack_irq, tx_abort_irq, tx_tmo_irq;
  logic [7:0] mon_out, rx_data;
  logic rx_first, rx_byte_irq, rx_eom_irq, rx_err_irq;

  assign mx_in_n = mx_n;
  assign mon_in  = mon_out;
  assign mr_in_n = ovr ? ~ovr_act : mr_n;

  mon_hs dut (.clk, .rst_n, .frame_tick, .tx_data, .tx_wr, .tx_ctrl, .tmo_en,
    .rx_en, .rx_ie, .rx_take, .mx_in_n, .mr_in_n, .mon_in, .mx_n, .mr_n, .mon_out,
    .tx_busy, .tx_ack_irq, .tx_abort_irq, .tx_tmo_irq, .rx_data, .rx_first,
    .rx_byte_irq, .rx_eom_irq, .rx_err_irq);

  int checks = 0, errors = 0, cyc = 0, fc = 0;
  bit cmp_on = 0;

  task automatic chk(input string req, input string nm, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, nm, a, e, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) fc = 0; else fc = (fc + 1) % 4;
    frame_tick = rst_n && fc == 3;
  end

  // behavioural reference, stepped once per clock
  int  m_st, m_tmr;
  bit  m_mx, m_miss, m_mrp, m_quiet, m_pend, m_ack, m_abt, m_tmo;
  logic [7:0] m_pb, m_out, m_rd;
  bit  m_mr, m_mxp, m_full, m_in, m_rq, m_first, m_byte, m_err, m_eom;

  task automatic m_reset();
    m_st = 0; m_tmr = 0; m_mx = 0; m_miss = 0; m_mrp = 0; m_quiet = 0; m_pend = 0;
    m_ack = 0; m_abt = 0; m_tmo = 0; m_pb = 0; m_out = 0; m_rd = 0;
    m_mr = 0; m_mxp = 0; m_full = 0; m_in = 0; m_rq = 0; m_first = 0;
    m_byte = 0; m_err = 0; m_eom = 0;
  endtask

  task automatic m_step();
    bit mxs, mrs, mr_own, ack;
    logic [7:0] ob;
    mxs = m_mx; ob = m_out; mr_own = m_mr;
    mrs = ovr ? ovr_act : m_mr;
    m_ack = 0; m_abt = 0; m_tmo = 0; m_byte = 0; m_err = 0; m_eom = 0;
    if (rx_take) m_full = 0;
    if (frame_tick) begin
      ack = mrs && !m_mrp;
      m_mrp = mrs;
      if (m_st == 2 && !tx_ctrl) begin m_st = 3; m_quiet = 0; end
      else if ((m_st == 0 || m_st == 2) && tx_ctrl && m_pend) begin
        m_out = m_pb; m_pend = 0; m_mx = 1; m_st = 1; m_tmr = 0; m_miss = 0;
      end else if (m_st == 1) begin
        if (ack) begin m_ack = 1; m_mx = 0; m_st = 2; end
        else if (!mrs && m_miss) begin m_abt = 1; m_mx = 0; m_st = 3; m_quiet = 0; end
        else if (tmo_en && m_tmr == 31) begin m_tmo = 1; m_mx = 0; m_st = 3; m_quiet = 0; end
        else begin m_miss = !mrs; m_tmr++; end
      end else if (m_st == 3) begin
        if (mrs) m_quiet = 0;
        else if (m_quiet) m_st = 0;
        else m_quiet = 1;
      end
      if (!rx_en) m_mr = 0;
      else if (mxs && !m_mxp) begin
        if (m_full) m_err = 1;
        else begin
          m_rd = ob; m_full = 1; m_mr = 1; m_byte = rx_ie; m_first = !m_in; m_in = 1;
        end
      end else if (!mxs) m_mr = 0;
      if (!mxs && !mr_own && m_in) begin
        if (m_rq) begin m_in = 0; m_eom = rx_ie; m_rq = 0; end
        else m_rq = 1;
      end else m_rq = 0;
      m_mxp = mxs;
    end
    if (tx_wr) begin m_pend = 1; m_pb = tx_data; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_reset(); else m_step();
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2", "mx_n", mx_n, !m_mx);
      chk("R2", "mon_out", mon_out, m_out);
      chk("R6", "tx_busy", tx_busy, m_st != 0);
      chk("R3", "tx_ack_irq", tx_ack_irq, m_ack);
      chk("R4", "tx_abort_irq", tx_abort_irq, m_abt);
      chk("R5", "tx_tmo_irq", tx_tmo_irq, m_tmo);
      chk("R7", "mr_n", mr_n, !m_mr);
      chk("R7", "rx_data", rx_data, m_rd);
      chk("R7", "rx_first", rx_first, m_first);
      chk("R8", "rx_byte_irq", rx_byte_irq, m_byte);
      chk("R9", "rx_err_irq", rx_err_irq, m_err);
      chk("R10", "rx_eom_irq", rx_eom_irq, m_eom);
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R6 watchdog: run not finished actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  logic [7:0] got[$];
  bit gotf[$];
  int n_ack, n_abt, n_tmo, n_eom, n_err, t_start, t_tmo, busy_at_rel;

  task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input bit take, input int gap, input int rel_at);
    logic [7:0] bs[3];
    int sent = 1, wdel = -1, guard = 0;
    bit seen_busy = 0, done = 0;
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    got.delete(); gotf.delete();
    n_ack = 0; n_abt = 0; n_tmo = 0; n_eom = 0; n_err = 0; t_start = 0; t_tmo = 0; busy_at_rel = 0;
    @(negedge clk);
    tx_data = bs[0]; tx_wr = 1; tx_ctrl = 1;
    while (!done && guard < 800) begin
      @(negedge clk);
      guard++;
      tx_wr = 0; rx_take = 0;
      if (tx_busy && !seen_busy) begin seen_busy = 1; t_start = cyc; end
      if (rx_byte_irq) begin got.push_back(rx_data); gotf.push_back(rx_first); end
      if (rx_eom_irq) n_eom++;
      if (rx_err_irq) n_err++;
      if (tx_ack_irq) begin
        n_ack++;
        if (take) rx_take = 1;
        if (sent < n) wdel = gap; else tx_ctrl = 0;
      end
      if (wdel == 0) begin tx_data = bs[sent]; tx_wr = 1; sent++; wdel = -1; end
      else if (wdel > 0) wdel--;
      if (tx_abort_irq || tx_tmo_irq) begin
        if (tx_abort_irq) n_abt++;
        if (tx_tmo_irq) begin n_tmo++; t_tmo = cyc; end
        tx_ctrl = 0; ovr = 0;
      end
      if (rel_at > 0 && guard == rel_at) begin busy_at_rel = tx_busy; ovr_act = 0; end
      if (seen_busy && !tx_busy) done = 1;
    end
    repeat (12) begin
      @(negedge clk);
      tx_wr = 0; rx_take = 0;
      if (rx_eom_irq) n_eom++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mx_n", mx_n, 1); chk("R1", "mr_n", mr_n, 1); chk("R1", "tx_busy", tx_busy, 0);
    chk("R1", "irqs", {tx_ack_irq, tx_abort_irq, tx_tmo_irq, rx_byte_irq, rx_eom_irq, rx_err_irq}, 0);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    chk("R1", "mx_n after reset", mx_n, 1);
    repeat (8) @(negedge clk);

    tmo_en = 1;
    send(3, 8'hA5, 8'h3C, 8'h0F, 1, 0, 0);
    chk("R7", "bytes received", got.size(), 3);
    if (got.size() == 3) begin
      chk("R7", "byte0", got[0], 8'hA5); chk("R7", "byte1", got[1], 8'h3C); chk("R7", "byte2", got[2], 8'h0F);
      chk("R7", "first flag byte0", gotf[0], 1); chk("R7", "first flag byte1", gotf[1], 0);
    end
    chk("R3", "acks", n_ack, 3);
    chk("R10", "end of message", n_eom, 1);
    chk("R6", "busy cleared", tx_busy, 0);

    rx_ie = 0;
    send(1, 8'h5A, 0, 0, 1, 0, 0);
    chk("R8", "no byte irq with rx_ie=0", got.size(), 0);
    chk("R8", "still acknowledged", n_ack, 1);
    chk("R8", "captured anyway", rx_data, 8'h5A);
    chk("R10", "no eom irq with rx_ie=0", n_eom, 0);
    rx_ie = 1;

    rx_en = 0;
    send(1, 8'h77, 0, 0, 1, 0, 0);
    chk("R8", "no ack with rx_en=0", n_ack, 0);
    chk("R4", "abort on silent receiver", n_abt, 1);
    chk("R8", "mr_n idle", mr_n, 1);
    rx_en = 1;

    send(2, 8'h11, 8'h22, 0, 0, 0, 0);
    chk("R9", "refused byte", n_err, 1);
    chk("R4", "abort after refusal", n_abt, 1);
    chk("R9", "rx_data kept", rx_data, 8'h11);
    @(negedge clk); rx_take = 1; @(negedge clk); rx_take = 0;

    ovr = 1; ovr_act = 1;
    repeat (16) @(negedge clk);
    send(1, 8'hC3, 0, 0, 1, 0, 0);
    chk("R5", "timeout raised", n_tmo, 1);
    chk("R5", "timeout after 32 frames", t_tmo - t_start, 32 * 4);
    @(negedge clk); rx_take = 1; @(negedge clk); rx_take = 0;

    tmo_en = 0; ovr = 1; ovr_act = 1;
    repeat (16) @(negedge clk);
    send(1, 8'h96, 0, 0, 1, 0, 200);
    chk("R5", "no timeout when disabled", n_tmo, 0);
    chk("R5", "still waiting at 50 frames", busy_at_rel, 1);
    chk("R4", "abort after release", n_abt, 1);
    @(negedge clk); rx_take = 1; @(negedge clk); rx_take = 0;
    tmo_en = 1;

    send(2, 8'hE1, 8'h2E, 0, 1, 3, 0);
    chk("R3", "slow host bytes", got.size(), 2);
    chk("R3", "slow host acks", n_ack, 2);

    cmp_on = 0;
    summary();
    $finish;
  end
endmodule